// File: doc/BRIEF.md
# Grouped Pin Toggle Interrupt Unit

This block monitors a bank of general-purpose input pins and raises one of two sticky interrupt flags when an enabled pin changes level. Rising and falling transitions both count. The pins are split into a wide low group and a narrow high group. Each group has its own per-pin enable mask and its own flag. A flag stays set until software writes a 1 to its bit through the register write port.

Each pin first passes through a sampling stage and then a synchronizing stage. The masked difference between those two stages is registered before it sets the flag, so the delay from pin edge to flag is fixed. The detector sees only the pin level, so a pin that the chip drives as an output still raises its flag when it toggles.

In parallel, an unclocked comparison of each live pin level against its last sampled level drives a wake request. Power control logic can use this request while the clock is stopped.

Top module: `pin_toggle_irq`

## Requirements
- R1: Pins 0 to 7 belong to group 0 and can set only `flag[0]`. Pins 8 to 11 belong to group 1 and can set only `flag[1]`.
- R2: A level change on an enabled pin sets its group flag, whether the change is rising or falling.
- R3: A write to address 0 loads the group 0 mask from `wrData[7:0]`. A write to address 1 loads the group 1 mask from `wrData[3:0]`. A pin whose mask bit is 0 never sets its flag.
- R4: A flag first reads 1 after the third rising clock edge, counting the edge that first samples the new pin level. It reads 0 after the first and second of those edges.
- R5: A write to address 2 clears flag g when `wrData[g]` is 1 and leaves flag g unchanged when that bit is 0. A write to address 3 changes nothing.
- R6: If a qualifying toggle would set a flag on the same edge that a clear write hits it, the flag stays 1.
- R7: Changing a mask while the pins are held steady never sets a flag.
- R8: `wakeReq` is 1, with no clock edge needed, while any enabled pin differs from its last sampled level. It returns to 0 once the new level is sampled, and a disabled pin never raises it.
- R9: A synchronous reset (`rstN` low) clears both flags and both masks. It also loads the pin history with the current pin levels, so a pin level held through reset does not count as a change.
- R10: A set flag stays 1 after the pin goes back to its old level and while the pins stay steady, until it is cleared.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for sampling and registers |
| rstN | input | 1 | Synchronous reset, active low |
| pinIn | input | 12 | Monitored pin levels, group 0 in the low 8 bits |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 2 | Register address: 0 mask group 0, 1 mask group 1, 2 flag clear |
| wrData | input | 8 | Register write data |
| flag | output | 2 | Sticky interrupt flags, bit g for group g |
| wakeReq | output | 1 | Unclocked request: an enabled pin differs from its sampled level |

## Verification
The bench uses the default split of an 8-pin group and a 4-pin group. With this split it can toggle every mask bit of the full-width group and show that the mask register data above bit 3 has no pins behind it in the narrow group. The uneven split also places the group boundary between bit 7 and bit 8. The vectors change pins on both sides of that boundary at once, which shows that each flag responds only to its own group. The wake path is tested by stopping the clock, so the unclocked comparison is observed on its own, separate from the three-stage flag pipeline.

// File: rtl/pcirq_pkg.sv
package pcirq_pkg;
  localparam int REG_W   = 8;
  localparam int NUM_GRP = 2;

  localparam logic [1:0] ADDR_MASK0 = 2'd0;
  localparam logic [1:0] ADDR_MASK1 = 2'd1;
  localparam logic [1:0] ADDR_CLEAR = 2'd2;

  // strobes from register decode to the detection datapath
  typedef struct packed {
    logic [NUM_GRP-1:0] wrMask;
    logic [NUM_GRP-1:0] clrFlag;
    logic [REG_W-1:0]   data;
  } pcStrobe_t;
endpackage

// File: rtl/pcirq_ctrl.sv
module pcirq_ctrl
  import pcirq_pkg::*;
(
  input  logic             wrEn,
  input  logic [1:0]       wrAddr,
  input  logic [REG_W-1:0] wrData,
  output pcStrobe_t        strobe
);
  always_comb begin
    strobe      = '0;
    strobe.data = wrData;
    if (wrEn) begin
      unique case (wrAddr)
        ADDR_MASK0: strobe.wrMask[0] = 1'b1;
        ADDR_MASK1: strobe.wrMask[1] = 1'b1;
        ADDR_CLEAR: strobe.clrFlag   = wrData[NUM_GRP-1:0];
        default:    strobe.clrFlag   = '0;
      endcase
    end
  end
endmodule

// File: rtl/pcirq_group.sv
module pcirq_group #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] pins,
  input  logic         maskWr,
  input  logic [W-1:0] maskData,
  input  logic         flagClr,
  output logic         flag,
  output logic         wake
);
  logic [W-1:0] mask;
  logic [W-1:0] pinLat;
  logic [W-1:0] pinSync;
  logic         toggleHit;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      mask      <= '0;
      pinLat    <= pins;
      pinSync   <= pins;
      toggleHit <= 1'b0;
      flag      <= 1'b0;
    end else begin
      if (maskWr) mask <= maskData;
      pinLat    <= pins;
      pinSync   <= pinLat;
      toggleHit <= |((pinLat ^ pinSync) & mask);
      // a new hit outranks a clear on the same edge
      if (toggleHit)    flag <= 1'b1;
      else if (flagClr) flag <= 1'b0;
    end
  end

  // unclocked path: live level against last sampled level
  assign wake = |((pins ^ pinLat) & mask);
endmodule

// File: rtl/pcirq_dpath.sv
module pcirq_dpath
  import pcirq_pkg::*;
#(
  parameter  int GRP0_W = 8,
  parameter  int GRP1_W = 4,
  localparam int NPINS  = GRP0_W + GRP1_W
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NPINS-1:0]   pinIn,
  input  pcStrobe_t          strobe,
  output logic [NUM_GRP-1:0] flag,
  output logic               wakeReq
);
  logic [NUM_GRP-1:0] grpWake;

  for (genvar g = 0; g < NUM_GRP; g++) begin : gGrp
    localparam int GW  = (g == 0) ? GRP0_W : GRP1_W;
    localparam int LSB = (g == 0) ? 0 : GRP0_W;
    pcirq_group #(.W(GW)) uGroup (
      .clk      (clk),
      .rstN     (rstN),
      .pins     (pinIn[LSB +: GW]),
      .maskWr   (strobe.wrMask[g]),
      .maskData (strobe.data[GW-1:0]),
      .flagClr  (strobe.clrFlag[g]),
      .flag     (flag[g]),
      .wake     (grpWake[g])
    );
  end

  assign wakeReq = |grpWake;
endmodule

// File: rtl/pin_toggle_irq.sv
module pin_toggle_irq
  import pcirq_pkg::*;
#(
  parameter  int GRP0_W = 8,
  parameter  int GRP1_W = 4,
  localparam int NPINS  = GRP0_W + GRP1_W
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NPINS-1:0]   pinIn,
  input  logic               wrEn,
  input  logic [1:0]         wrAddr,
  input  logic [REG_W-1:0]   wrData,
  output logic [NUM_GRP-1:0] flag,
  output logic               wakeReq
);
  pcStrobe_t strobe;

  pcirq_ctrl uCtrl (
    .wrEn   (wrEn),
    .wrAddr (wrAddr),
    .wrData (wrData),
    .strobe (strobe)
  );

  pcirq_dpath #(.GRP0_W(GRP0_W), .GRP1_W(GRP1_W)) uDpath (
    .clk     (clk),
    .rstN    (rstN),
    .pinIn   (pinIn),
    .strobe  (strobe),
    .flag    (flag),
    .wakeReq (wakeReq)
  );
endmodule

// File: rtl/pin_toggle_irq_chk.sv
module pin_toggle_irq_chk #(
  parameter  int GRP0_W = 8,
  parameter  int GRP1_W = 4,
  localparam int NPINS  = GRP0_W + GRP1_W
) (
  input logic             clk,
  input logic             rstN,
  input logic [NPINS-1:0] pinIn,
  input logic             wrEn,
  input logic [1:0]       wrAddr,
  input logic [7:0]       wrData,
  input logic [1:0]       flag,
  input logic             wakeReq
);
  // R4: a flag only rises when its group's pins changed exactly three edges earlier
  p_flag0_cause_r4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(flag[0]) |-> $past(pinIn[GRP0_W-1:0], 3) != $past(pinIn[GRP0_W-1:0], 4));

  p_flag1_cause_r4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(flag[1]) |-> $past(pinIn[NPINS-1:GRP0_W], 3) != $past(pinIn[NPINS-1:GRP0_W], 4));

  // R5 / R10: a flag falls only after a clear write naming it
  p_flag0_fall_r5: assert property (@(posedge clk) disable iff (!rstN)
    $fell(flag[0]) |-> $past(wrEn && wrAddr == 2'd2 && wrData[0]));

  p_flag1_fall_r10: assert property (@(posedge clk) disable iff (!rstN)
    $fell(flag[1]) |-> $past(wrEn && wrAddr == 2'd2 && wrData[1]));

  // R9: leaving reset, both flags are clear
  p_reset_clear_r9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> flag == 2'b00);
endmodule

bind pin_toggle_irq pin_toggle_irq_chk #(.GRP0_W(GRP0_W), .GRP1_W(GRP1_W)) uChk (.*);

// File: tb/test_pin_toggle_irq.sv
module test_pin_toggle_irq;
  logic        clk = 1'b0;
  bit          clkRun = 1'b1;
  logic        rstN;
  logic [11:0] pinIn;
  logic        wrEn;
  logic [1:0]  wrAddr;
  logic [7:0]  wrData;
  logic [1:0]  flag;
  logic        wakeReq;
  int checks = 0;
  int errors = 0;

  always #5 if (clkRun) clk = ~clk;

  pin_toggle_irq i_pin_toggle_irq (
    .clk(clk), .rstN(rstN), .pinIn(pinIn), .wrEn(wrEn),
    .wrAddr(wrAddr), .wrData(wrData), .flag(flag), .wakeReq(wakeReq)
  );

  // {mask0[7:0], mask1[3:0], new pins[11:0], expected flags[1:0]}
  localparam logic [25:0] VEC [10] = '{
    {8'hFF, 4'h0, 12'h001, 2'b01},
    {8'hFF, 4'h0, 12'h000, 2'b01},
    {8'h00, 4'hF, 12'h100, 2'b10},
    {8'h00, 4'hF, 12'h0FF, 2'b10},
    {8'h0F, 4'h0, 12'h0F0, 2'b01},
    {8'h0F, 4'h0, 12'h000, 2'b00},
    {8'h80, 4'h8, 12'h880, 2'b11},
    {8'h7F, 4'h7, 12'h000, 2'b00},
    {8'hFF, 4'hF, 12'hFFF, 2'b11},
    {8'h01, 4'h1, 12'hFFE, 2'b01}
  };

  task automatic chk(input string tag, input logic [1:0] act, input logic [1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %b expected %b", tag, act, exp);
    end
  endtask

  task automatic wrReg(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog all requirements actual hung expected done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rstN = 1'b0; pinIn = 12'h5A3; wrEn = 1'b0; wrAddr = '0; wrData = '0;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    repeat (4) @(negedge clk);
    chk("R9 flags after reset", flag, 2'b00);
    chk("R9 wake after reset", {1'b0, wakeReq}, 2'b00);
    pinIn = 12'h000;
    repeat (4) @(negedge clk);
    chk("R9 masks cleared", flag, 2'b00);

    // vector table: R1 R2 R3
    for (int i = 0; i < 10; i++) begin
      wrReg(2'd0, VEC[i][25:18]);
      wrReg(2'd1, {4'h0, VEC[i][17:14]});
      wrReg(2'd2, 8'h03);
      @(negedge clk);
      pinIn = VEC[i][13:2];
      repeat (4) @(negedge clk);
      chk($sformatf("R1 R2 R3 vector %0d", i), flag, VEC[i][1:0]);
      wrReg(2'd2, 8'h03);
    end

    // R4 latency, pins now FFE
    wrReg(2'd0, 8'hFF); wrReg(2'd1, 8'h0F); wrReg(2'd2, 8'h03);
    @(negedge clk); pinIn = 12'hFFC;
    @(negedge clk); chk("R4 after edge 1", flag, 2'b00);
    @(negedge clk); chk("R4 after edge 2", flag, 2'b00);
    @(negedge clk); chk("R4 after edge 3", flag, 2'b01);

    // R10 sticky
    pinIn = 12'hFFE;
    repeat (12) @(negedge clk);
    chk("R10 sticky", flag, 2'b01);

    // R5 selective clear
    pinIn = 12'h7FE;
    repeat (4) @(negedge clk);
    chk("R1 group 1 set", flag, 2'b11);
    wrReg(2'd2, 8'h01); chk("R5 clear bit 0 only", flag, 2'b10);
    wrReg(2'd2, 8'h00); chk("R5 zero bits keep", flag, 2'b10);
    wrReg(2'd3, 8'hFF); chk("R5 address 3 no effect", flag, 2'b10);
    wrReg(2'd2, 8'h02); chk("R5 clear bit 1", flag, 2'b00);

    // R6 set beats clear
    @(negedge clk); pinIn = 12'h7FF;
    @(negedge clk);
    @(negedge clk); wrEn = 1'b1; wrAddr = 2'd2; wrData = 8'h01;
    @(negedge clk); wrEn = 1'b0;
    chk("R6 set wins", flag, 2'b01);
    wrReg(2'd2, 8'h03); chk("R5 clear after R6", flag, 2'b00);

    // R7 mask change with steady pins
    wrReg(2'd0, 8'h00); wrReg(2'd1, 8'h00);
    @(negedge clk); pinIn = 12'h000;
    repeat (4) @(negedge clk);
    wrReg(2'd0, 8'hFF); wrReg(2'd1, 8'h0F);
    repeat (5) @(negedge clk);
    chk("R7 mask change steady", flag, 2'b00);

    // R8 wake with clock stopped
    wrReg(2'd0, 8'hFE);
    @(negedge clk); clkRun = 1'b0;
    #3 pinIn = 12'h001;
    #2 chk("R8 masked pin no wake", {1'b0, wakeReq}, 2'b00);
    pinIn = 12'h003;
    #2 chk("R8 wake without clock", {1'b0, wakeReq}, 2'b01);
    chk("R8 no flag without clock", flag, 2'b00);
    clkRun = 1'b1;
    @(negedge clk); chk("R8 wake drops once sampled", {1'b0, wakeReq}, 2'b00);
    repeat (3) @(negedge clk);
    chk("R8 flag after clock resumes", flag, 2'b01);

    // R9 reset mid-run
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk); chk("R9 reset clears flags", flag, 2'b00);
    pinIn = 12'hFFC;
    repeat (4) @(negedge clk);
    chk("R9 reset clears masks", flag, 2'b00);
    chk("R9 no wake with masks cleared", {1'b0, wakeReq}, 2'b00);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule